// File: doc/BRIEF.md
# SIMD Lane Divergence and Reconvergence Controller

This block keeps the per-lane activity mask of a SIMD core whose lanes share one program counter. When a predicated branch sends lanes in different directions, software brackets the two paths with a split and a join. The block runs the two sides one after the other and then brings the lanes back together. A split saves the mask in force before the split and records the lanes that must run the other side. It then lets only the lanes whose predicate holds continue. The first join reached afterwards sends the program counter back to the instruction after the split and runs the waiting lanes. The second join lets execution fall through with the saved mask restored. The records live in a hardware stack, so splits nest. Each nesting level takes two stack entries.

The block also screens ordinary control-flow instructions. If only some of the active lanes would take such an instruction, the block raises a one-cycle divergence flag. It also gives the datapath a per-lane execute enable for the instruction now being issued. Splits and joins always act once for the whole group of lanes and are never gated. A split that does not fit in the stack raises a sticky overflow flag. A join with nothing to pop raises a sticky underflow flag.

Top module: `simd_reconv_unit`

## Requirements
- R1: After reset every bit of lane_mask_o is 1, and redirect_valid_o, diverge_o, overflow_o and underflow_o are 0.
- R2: A valid split (opcode 0x3b) with at least two free stack entries sets lane_mask_o, on the next clock edge, to the old mask ANDed with the effective predicate.
- R3: The first join (opcode 0x3c) after a split sets lane_mask_o to the lanes that were active before that split and whose predicate was false. In the same cycle, redirect_valid_o is high for exactly one cycle and redirect_pc_o equals the split's PC plus 4.
- R4: The second join for a split restores lane_mask_o to the value held before that split, with redirect_valid_o low.
- R5: Splits nest. Joins unwind the inner split's two records before the outer split's two records, and each inner record's waiting lanes are a subset of the mask that was active at the inner split.
- R6: A split issued with fewer than two free entries (default depth 16, so a ninth nested split) sets overflow_o. The flag stays set. Neither the mask nor the stack changes, so the eight earlier levels still unwind correctly.
- R7: A join on an empty stack sets underflow_o, which stays set. The mask does not change and no redirect is produced.
- R8: For a valid control-flow instruction (branch_i high) that is neither a split nor a join, diverge_o pulses for one cycle on the next edge when the number of active lanes with a true effective predicate is neither zero nor the number of active lanes. Splits and joins never raise diverge_o.
- R9: exec_mask_o is all ones while the opcode is a split or a join. For any other opcode it is lane_mask_o ANDed with the effective predicate. It is combinational from the inputs.
- R10: An invalid cycle, or any valid opcode other than split and join, leaves lane_mask_o unchanged.
- R11: The effective predicate is pred_i when predicated_i is 1 and all ones otherwise. An unpredicated split therefore keeps every active lane, and its first join runs an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is issued this cycle |
| opcode_i | input | 6 | Decoded opcode (0x3b split, 0x3c join) |
| branch_i | input | 1 | Issued instruction is a control-flow instruction |
| predicated_i | input | 1 | Issued instruction uses a predicate |
| pred_i | input | N_LANES | Per-lane predicate value |
| pc_i | input | PC_W | PC of the issued instruction |
| lane_mask_o | output | N_LANES | Current active lane mask |
| exec_mask_o | output | N_LANES | Per-lane execute enable for the issued instruction |
| redirect_valid_o | output | 1 | One-cycle PC redirect strobe |
| redirect_pc_o | output | PC_W | Redirect target |
| diverge_o | output | 1 | One-cycle divergent control-flow flag |
| overflow_o | output | 1 | Sticky stack overflow flag |
| underflow_o | output | 1 | Sticky stack underflow flag |

## Verification
The hardest state to reach is a completely full stack that still holds consistent records. The stimulus nests eight splits with an all-true predicate, so the mask stays wide open while every entry fills. It then issues a ninth split whose predicate would zero the mask. Sixteen joins follow. Their alternating empty and full masks, and their redirect targets in reverse order, show that the rejected split left both the stack and the mask untouched. A final join on the now empty stack checks underflow. Divergence is also probed with a narrowed mask, where an instruction that looks divergent across all lanes is uniform across the active ones.

// File: rtl/simd_reconv_pkg.sv
package simd_reconv_pkg;

    localparam int          OPC_W     = 6;
    localparam logic [5:0]  OPC_SPLIT = 6'h3b;
    localparam logic [5:0]  OPC_JOIN  = 6'h3c;

    typedef enum logic [1:0] {
        ACT_IDLE,
        ACT_SPLIT,
        ACT_JOIN,
        ACT_BRANCH
    } act_e;

    function automatic act_e classify(input logic vld, input logic [OPC_W-1:0] opc,
                                      input logic is_branch);
        act_e a;
        if (!vld)                  a = ACT_IDLE;
        else if (opc == OPC_SPLIT) a = ACT_SPLIT;
        else if (opc == OPC_JOIN)  a = ACT_JOIN;
        else if (is_branch)        a = ACT_BRANCH;
        else                       a = ACT_IDLE;
        return a;
    endfunction

    function automatic logic is_warp_op(input logic [OPC_W-1:0] opc);
        return (opc == OPC_SPLIT) || (opc == OPC_JOIN);
    endfunction

endpackage

// File: rtl/rs_lane_gate.sv
module rs_lane_gate #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] pred_i,
    input  logic             predicated_i,
    input  logic             warp_op_i,
    output logic [LANES-1:0] eff_pred_o,
    output logic [LANES-1:0] exec_o
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign eff_pred_o[l] = predicated_i ? pred_i[l] : 1'b1;
        assign exec_o[l]     = warp_op_i | (mask_i[l] & eff_pred_o[l]);
    end
endmodule

// File: rtl/rs_div_check.sv
module rs_div_check #(
    parameter int LANES = 8
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] eff_pred_i,
    output logic             diverge_o
);
    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] n_active;
    logic [CNT_W-1:0] n_taken;

    always_comb begin
        n_active = '0;
        n_taken  = '0;
        for (int l = 0; l < LANES; l++) begin
            n_active = n_active + CNT_W'(mask_i[l]);
            n_taken  = n_taken + CNT_W'(mask_i[l] & eff_pred_i[l]);
        end
        diverge_o = (n_taken != '0) && (n_taken != n_active);
    end
endmodule

// File: rtl/rs_div_stack.sv
module rs_div_stack #(
    parameter int LANES = 8,
    parameter int DEPTH = 16,
    parameter int PC_W  = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_pair_i,
    input  logic [LANES-1:0] base_mask_i,
    input  logic [LANES-1:0] alt_mask_i,
    input  logic [PC_W-1:0]  alt_pc_i,
    input  logic             pop_i,
    output logic [LANES-1:0] top_mask_o,
    output logic [PC_W-1:0]  top_pc_o,
    output logic             top_fall_o,
    output logic             room2_o,
    output logic             empty_o
);
    localparam int SP_W  = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [LANES-1:0] mask;
        logic [PC_W-1:0]  pc;
        logic             fall;
    } entry_t;

    entry_t           mem [DEPTH];
    logic [SP_W-1:0]  sp_q;
    logic [IDX_W-1:0] wr_lo, wr_hi, rd_idx;
    entry_t           top_e;

    assign wr_lo   = sp_q[IDX_W-1:0];
    assign wr_hi   = IDX_W'(sp_q + SP_W'(1));
    assign rd_idx  = IDX_W'(sp_q - SP_W'(1));
    assign empty_o = (sp_q == '0);
    assign room2_o = (sp_q <= SP_W'(DEPTH - 2));
    assign top_e   = empty_o ? '0 : mem[rd_idx];

    assign top_mask_o = top_e.mask;
    assign top_pc_o   = top_e.pc;
    assign top_fall_o = top_e.fall;

    always_ff @(posedge clk) begin
        if (push_pair_i && room2_o) begin
            mem[wr_lo] <= '{mask: base_mask_i, pc: '0,       fall: 1'b1};
            mem[wr_hi] <= '{mask: alt_mask_i,  pc: alt_pc_i, fall: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q <= '0;
        end else if (push_pair_i && room2_o) begin
            sp_q <= sp_q + SP_W'(2);
        end else if (pop_i && !empty_o) begin
            sp_q <= sp_q - SP_W'(1);
        end
    end
endmodule

// File: rtl/simd_reconv_unit.sv
module simd_reconv_unit
    import simd_reconv_pkg::*;
#(
    parameter int N_LANES     = 8,
    parameter int STACK_DEPTH = 16,
    parameter int PC_W        = 32,
    parameter int PC_STEP     = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [OPC_W-1:0]   opcode_i,
    input  logic               branch_i,
    input  logic               predicated_i,
    input  logic [N_LANES-1:0] pred_i,
    input  logic [PC_W-1:0]    pc_i,
    output logic [N_LANES-1:0] lane_mask_o,
    output logic [N_LANES-1:0] exec_mask_o,
    output logic               redirect_valid_o,
    output logic [PC_W-1:0]    redirect_pc_o,
    output logic               diverge_o,
    output logic               overflow_o,
    output logic               underflow_o
);
    act_e               act;
    logic [N_LANES-1:0] mask_q;
    logic [N_LANES-1:0] eff_pred;
    logic               div_raw;
    logic               stk_room2, stk_empty, top_fall;
    logic [N_LANES-1:0] top_mask;
    logic [PC_W-1:0]    top_pc;
    logic               do_push, do_pop;
    logic               redir_q, div_q, ovf_q, unf_q;
    logic [PC_W-1:0]    redir_pc_q;

    assign act     = classify(valid_i, opcode_i, branch_i);
    assign do_push = (act == ACT_SPLIT) && stk_room2;
    assign do_pop  = (act == ACT_JOIN) && !stk_empty;

    rs_lane_gate #(.LANES(N_LANES)) u_gate (
        .mask_i      (mask_q),
        .pred_i      (pred_i),
        .predicated_i(predicated_i),
        .warp_op_i   (is_warp_op(opcode_i)),
        .eff_pred_o  (eff_pred),
        .exec_o      (exec_mask_o)
    );

    rs_div_check #(.LANES(N_LANES)) u_div (
        .mask_i    (mask_q),
        .eff_pred_i(eff_pred),
        .diverge_o (div_raw)
    );

    rs_div_stack #(.LANES(N_LANES), .DEPTH(STACK_DEPTH), .PC_W(PC_W)) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_pair_i(do_push),
        .base_mask_i(mask_q),
        .alt_mask_i (mask_q & ~eff_pred),
        .alt_pc_i   (pc_i),
        .pop_i      (do_pop),
        .top_mask_o (top_mask),
        .top_pc_o   (top_pc),
        .top_fall_o (top_fall),
        .room2_o    (stk_room2),
        .empty_o    (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q     <= '1;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
            div_q      <= 1'b0;
            ovf_q      <= 1'b0;
            unf_q      <= 1'b0;
        end else begin
            redir_q <= 1'b0;
            div_q   <= 1'b0;
            unique case (act)
                ACT_SPLIT: begin
                    if (stk_room2) mask_q <= mask_q & eff_pred;
                    else           ovf_q  <= 1'b1;
                end
                ACT_JOIN: begin
                    if (stk_empty) begin
                        unf_q <= 1'b1;
                    end else begin
                        mask_q <= top_mask;
                        if (!top_fall) begin
                            redir_q    <= 1'b1;
                            redir_pc_q <= top_pc + PC_W'(PC_STEP);
                        end
                    end
                end
                ACT_BRANCH: div_q <= div_raw;
                default: ;
            endcase
        end
    end

    assign lane_mask_o      = mask_q;
    assign redirect_valid_o = redir_q;
    assign redirect_pc_o    = redir_pc_q;
    assign diverge_o        = div_q;
    assign overflow_o       = ovf_q;
    assign underflow_o      = unf_q;
endmodule

// File: rtl/simd_reconv_checker.sv
module simd_reconv_checker
    import simd_reconv_pkg::*;
#(
    parameter int N_LANES = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               valid_i,
    input logic [OPC_W-1:0]   opcode_i,
    input logic               branch_i,
    input logic               predicated_i,
    input logic [N_LANES-1:0] pred_i,
    input logic [N_LANES-1:0] lane_mask_o,
    input logic [N_LANES-1:0] exec_mask_o,
    input logic               redirect_valid_o,
    input logic               diverge_o,
    input logic               overflow_o,
    input logic               underflow_o,
    input logic               stk_room2
);
    logic [N_LANES-1:0] eff;
    logic               is_split, is_join;

    assign eff      = predicated_i ? pred_i : '1;
    assign is_split = valid_i && (opcode_i == OPC_SPLIT);
    assign is_join  = valid_i && (opcode_i == OPC_JOIN);

    p_all_active_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lane_mask_o == '1));

    p_split_narrows_r2: assert property (@(posedge clk) disable iff (rst)
        (is_split && stk_room2) |=> (lane_mask_o == $past(lane_mask_o & eff)));

    p_redirect_from_join_r3: assert property (@(posedge clk) disable iff (rst)
        redirect_valid_o |-> $past(is_join));

    p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    p_underflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        underflow_o |=> underflow_o);

    p_diverge_source_r8: assert property (@(posedge clk) disable iff (rst)
        diverge_o |-> $past(valid_i && branch_i && !is_split && !is_join));

    p_exec_within_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !is_split && !is_join) |-> ((exec_mask_o & ~lane_mask_o) == '0));

    p_mask_held_r10: assert property (@(posedge clk) disable iff (rst)
        (!is_split && !is_join) |=> $stable(lane_mask_o));
endmodule

bind simd_reconv_unit simd_reconv_checker #(.N_LANES(N_LANES)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .valid_i         (valid_i),
    .opcode_i        (opcode_i),
    .branch_i        (branch_i),
    .predicated_i    (predicated_i),
    .pred_i          (pred_i),
    .lane_mask_o     (lane_mask_o),
    .exec_mask_o     (exec_mask_o),
    .redirect_valid_o(redirect_valid_o),
    .diverge_o       (diverge_o),
    .overflow_o      (overflow_o),
    .underflow_o     (underflow_o),
    .stk_room2       (stk_room2)
);

// File: tb/tb_simd_reconv_unit.sv
module tb_simd_reconv_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] SPL = 6'h3b;
    localparam logic [5:0] JN  = 6'h3c;
    localparam logic [5:0] ALU = 6'h05;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [5:0]  opcode_i = '0;
    logic        branch_i = 1'b0;
    logic        predicated_i = 1'b0;
    logic [7:0]  pred_i = '0;
    logic [31:0] pc_i = '0;
    logic [7:0]  lane_mask_o, exec_mask_o;
    logic        redirect_valid_o, diverge_o, overflow_o, underflow_o;
    logic [31:0] redirect_pc_o;

    int n_checks = 0;
    int n_fails  = 0;

    simd_reconv_unit dut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .opcode_i(opcode_i),
        .branch_i(branch_i), .predicated_i(predicated_i), .pred_i(pred_i),
        .pc_i(pc_i), .lane_mask_o(lane_mask_o), .exec_mask_o(exec_mask_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
        .diverge_o(diverge_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [5:0] op, input logic pr,
                         input logic [7:0] p, input logic br, input logic [31:0] pc);
        @(negedge clk);
        valid_i = v; opcode_i = op; predicated_i = pr; pred_i = p;
        branch_i = br; pc_i = pc;
        #1;
    endtask

    task automatic clock_it();
        @(posedge clk);
        #1;
        valid_i = 1'b0; branch_i = 1'b0;
    endtask

    task automatic issue(input logic [5:0] op, input logic pr, input logic [7:0] p,
                         input logic br, input logic [31:0] pc);
        drive(1'b1, op, pr, p, br, pc);
        clock_it();
    endtask

    task automatic idle();
        drive(1'b0, ALU, 1'b0, 8'h00, 1'b0, 32'h0);
        clock_it();
    endtask

    task automatic join_expect(input string req, input logic [7:0] m,
                               input logic rv, input logic [31:0] rpc);
        issue(JN, 1'b0, 8'h00, 1'b0, 32'h0);
        check({req, " mask"}, 32'(lane_mask_o), 32'(m));
        check({req, " redirect"}, 32'(redirect_valid_o), 32'(rv));
        if (rv) check({req, " target"}, redirect_pc_o, rpc);
    endtask

    task automatic t_reset();
        check("R1 mask", 32'(lane_mask_o), 32'hFF);
        check("R1 redirect", 32'(redirect_valid_o), 32'h0);
        check("R1 flags", {29'h0, diverge_o, overflow_o, underflow_o}, 32'h0);
    endtask

    task automatic t_basic();
        issue(SPL, 1'b1, 8'h0F, 1'b0, 32'h100);
        check("R2 split mask", 32'(lane_mask_o), 32'h0F);
        check("R2 no redirect", 32'(redirect_valid_o), 32'h0);
        join_expect("R3 first join", 8'hF0, 1'b1, 32'h104);
        idle();
        check("R3 redirect one cycle", 32'(redirect_valid_o), 32'h0);
        check("R3 mask held", 32'(lane_mask_o), 32'hF0);
        join_expect("R4 second join", 8'hFF, 1'b0, 32'h0);
    endtask

    task automatic t_nested();
        issue(SPL, 1'b1, 8'h33, 1'b0, 32'h200);
        check("R5 outer split", 32'(lane_mask_o), 32'h33);
        issue(SPL, 1'b1, 8'h0F, 1'b0, 32'h300);
        check("R5 inner split", 32'(lane_mask_o), 32'h03);
        join_expect("R5 inner first join", 8'h30, 1'b1, 32'h304);
        join_expect("R5 inner second join", 8'h33, 1'b0, 32'h0);
        join_expect("R5 outer first join", 8'hCC, 1'b1, 32'h204);
        join_expect("R5 outer second join", 8'hFF, 1'b0, 32'h0);
    endtask

    task automatic t_unpred();
        issue(SPL, 1'b0, 8'h00, 1'b0, 32'h40);
        check("R11 unpredicated split", 32'(lane_mask_o), 32'hFF);
        join_expect("R11 first join empty", 8'h00, 1'b1, 32'h44);
        join_expect("R11 second join", 8'hFF, 1'b0, 32'h0);
    endtask

    task automatic t_diverge();
        issue(ALU, 1'b1, 8'h0F, 1'b1, 32'h0);
        check("R8 divergent", 32'(diverge_o), 32'h1);
        idle();
        check("R8 pulse", 32'(diverge_o), 32'h0);
        issue(ALU, 1'b1, 8'hFF, 1'b1, 32'h0);
        check("R8 all taken", 32'(diverge_o), 32'h0);
        issue(ALU, 1'b1, 8'h00, 1'b1, 32'h0);
        check("R8 none taken", 32'(diverge_o), 32'h0);
        issue(ALU, 1'b0, 8'h0F, 1'b1, 32'h0);
        check("R8 unpredicated", 32'(diverge_o), 32'h0);
        issue(SPL, 1'b1, 8'h0F, 1'b1, 32'h500);
        check("R8 split never flags", 32'(diverge_o), 32'h0);
        issue(ALU, 1'b1, 8'h3F, 1'b1, 32'h0);
        check("R8 uniform among active", 32'(diverge_o), 32'h0);
        issue(ALU, 1'b1, 8'h03, 1'b1, 32'h0);
        check("R8 divergent among active", 32'(diverge_o), 32'h1);
        join_expect("R8 join", 8'hF0, 1'b1, 32'h504);
        join_expect("R8 join back", 8'hFF, 1'b0, 32'h0);
    endtask

    task automatic t_exec();
        drive(1'b1, ALU, 1'b1, 8'h5A, 1'b0, 32'h0);
        check("R9 exec predicated", 32'(exec_mask_o), 32'h5A);
        drive(1'b1, ALU, 1'b0, 8'h00, 1'b0, 32'h0);
        check("R9 exec unpredicated", 32'(exec_mask_o), 32'hFF);
        clock_it();
        issue(SPL, 1'b1, 8'h0F, 1'b0, 32'h600);
        drive(1'b1, ALU, 1'b0, 8'h00, 1'b0, 32'h0);
        check("R9 exec narrowed", 32'(exec_mask_o), 32'h0F);
        drive(1'b1, ALU, 1'b1, 8'h3C, 1'b0, 32'h0);
        check("R9 exec narrowed predicated", 32'(exec_mask_o), 32'h0C);
        drive(1'b1, JN, 1'b1, 8'h00, 1'b0, 32'h0);
        check("R9 exec join whole group", 32'(exec_mask_o), 32'hFF);
        clock_it();
        check("R9 join took effect", 32'(lane_mask_o), 32'hF0);
        join_expect("R9 join back", 8'hFF, 1'b0, 32'h0);
    endtask

    task automatic t_other();
        issue(SPL, 1'b1, 8'h0F, 1'b0, 32'h700);
        issue(ALU, 1'b1, 8'hF0, 1'b0, 32'h0);
        check("R10 other opcode", 32'(lane_mask_o), 32'h0F);
        drive(1'b0, SPL, 1'b1, 8'h00, 1'b0, 32'h0);
        clock_it();
        check("R10 invalid split", 32'(lane_mask_o), 32'h0F);
        drive(1'b0, JN, 1'b0, 8'h00, 1'b0, 32'h0);
        clock_it();
        check("R10 invalid join", 32'(lane_mask_o), 32'h0F);
        check("R10 no redirect", 32'(redirect_valid_o), 32'h0);
        join_expect("R10 join", 8'hF0, 1'b1, 32'h704);
        join_expect("R10 join back", 8'hFF, 1'b0, 32'h0);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 8; k++) issue(SPL, 1'b1, 8'hFF, 1'b0, 32'h1000 + 32'(k*16));
        check("R6 before full", 32'(overflow_o), 32'h0);
        issue(SPL, 1'b1, 8'h00, 1'b0, 32'h2000);
        check("R6 overflow set", 32'(overflow_o), 32'h1);
        check("R6 mask unchanged", 32'(lane_mask_o), 32'hFF);
        idle();
        check("R6 sticky", 32'(overflow_o), 32'h1);
        for (int k = 7; k >= 0; k--) begin
            join_expect("R6 unwind first", 8'h00, 1'b1, 32'h1004 + 32'(k*16));
            join_expect("R6 unwind second", 8'hFF, 1'b0, 32'h0);
        end
    endtask

    task automatic t_underflow();
        check("R7 clear before", 32'(underflow_o), 32'h0);
        join_expect("R7 empty join", 8'hFF, 1'b0, 32'h0);
        check("R7 underflow set", 32'(underflow_o), 32'h1);
        idle();
        check("R7 sticky", 32'(underflow_o), 32'h1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_nested();
        t_unpred();
        t_diverge();
        t_exec();
        t_other();
        t_overflow();
        t_underflow();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule